// File: doc/BRIEF.md
# Multi-lane SPI Bus Master

This block is an SPI bus master. Software-side logic pushes command words into a four-entry transmit queue. Each word carries the payload, the frame length, the target select line, the lane mode, the direction and a hold flag. The engine pops one word per frame and shifts it out on the serial pins. Received words go into a four-entry receive queue, where the host reads them back.

The block has four lane modes. The first is classic full-duplex, with one bit out on line 0 and one bit in on line 1 per SCK period. The other three are half-duplex modes that move 1, 2 or 4 bits per SCK period over shared data lines, either transmit-only or receive-only. Polarity, phase, SCK rate and the select-to-clock guard delays come from configuration inputs. An optional host-request input holds back the start of each transfer until an external agent allows it. Setting the hold flag chains frames under one select assertion. If the queue runs dry in the middle of a chain, the transfer ends cleanly.

Top module: `spi_mline_master`

## Requirements
- R1: After a synchronous reset, all four select outputs are high, no data line is driven (`sd_oe` = 0), SCK sits at the level of `cfg_cpol`, the receive queue is empty and the command queue is not full.
- R2: In full-duplex mode (lane code 0), a frame of `cmd_len_m1`+1 bits (1 to 32) is sent most significant bit first on line 0 while line 1 is sampled. The received bits are queued as one word, right-aligned.
- R3: In half-duplex modes, lane code 1 moves 1 bit per SCK period on line 0, code 2 moves 2 bits on lines 1:0, and code 3 moves 4 bits on lines 3:0. Groups go out most significant first, and line 0 carries the lowest bit of each group. The frame length must be a multiple of the lane count.
- R4: A half-duplex receive frame (`cmd_rd` = 1) drives no data line and queues one received word. A half-duplex transmit frame queues nothing.
- R5: SCK idles at `cfg_cpol`. With `cfg_cpha` = 0 the master samples on the leading edge of each SCK period; with `cfg_cpha` = 1 it samples on the trailing edge.
- R6: Each SCK half period lasts `cfg_div`+1 system clocks.
- R7: The 2-bit select field drives exactly one active-low select line, `cs_n[cmd_cs]`, low for the whole transfer.
- R8: The first SCK edge comes exactly `cfg_lead`+`cfg_div`+2 clocks after the select line falls. The select line rises exactly `cfg_lag`+2 clocks after the last SCK edge of a frame without hold.
- R9: When a frame has hold set and another word is queued, that word follows under the same select assertion. If the queue is empty at that point, the transfer ends and the select line rises `cfg_lag`+3 clocks after the last SCK edge.
- R10: While `cfg_hreq_en` is 1, no transfer starts while `hreq` is low.
- R11: The command queue holds 4 words. `cmd_full` is then high, and a push while full is dropped.
- R12: While the receive queue holds 4 words, the master waits before starting the next frame, so no received word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_div | input | 8 | SCK half period minus one, in clocks |
| cfg_lead | input | 8 | Select-to-clock guard setting |
| cfg_lag | input | 8 | Clock-to-deselect guard setting |
| cfg_hreq_en | input | 1 | Gate transfer starts on `hreq` |
| hreq | input | 1 | External start permission |
| cmd_we | input | 1 | Push a command word |
| cmd_data | input | 32 | Payload to transmit |
| cmd_len_m1 | input | 5 | Frame length minus one |
| cmd_cs | input | 2 | Select line index |
| cmd_lanes | input | 2 | 0 full duplex, 1/2/3 half duplex on 1/2/4 lines |
| cmd_rd | input | 1 | Half-duplex direction, 1 = receive |
| cmd_hold | input | 1 | Keep select asserted for the next word |
| cmd_full | output | 1 | Command queue full |
| rx_re | input | 1 | Pop the receive queue |
| rx_data | output | 32 | Oldest received word |
| rx_empty | output | 1 | Receive queue empty |
| sck | output | 1 | Serial clock |
| cs_n | output | 4 | Active-low select lines |
| sd_o | output | 4 | Data line output values |
| sd_oe | output | 4 | Data line output enables |
| sd_i | input | 4 | Data line input values |

## Verification
The assertions assume that pushed words keep the frame length a multiple of the lane count, that `hreq` is synchronous, and that configuration inputs change only while every select line is high. The bench changes polarity, phase, divider and delays only after the bus has gone idle and every expected frame has been seen. It sends only aligned lengths. It drives `hreq` and all command fields on the falling clock edge, and its slave model drives `sd_i` on the falling edge right after each sampling edge.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

    localparam int DW  = 32;
    localparam int LW  = $clog2(DW);
    localparam int NCS = 4;
    localparam int CSW = $clog2(NCS);
    localparam int NL  = 4;
    localparam int EW  = LW + 2;

    typedef enum logic [1:0] {
        LN_DUPLEX = 2'd0,
        LN_ONE    = 2'd1,
        LN_TWO    = 2'd2,
        LN_FOUR   = 2'd3
    } lane_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LEAD, ST_XFER, ST_DONE, ST_LINK, ST_LAG
    } state_e;

    typedef struct packed {
        logic            hold;
        logic [CSW-1:0]  cs;
        lane_e           lanes;
        logic            rd;
        logic [LW-1:0]   len_m1;
        logic [DW-1:0]   data;
    } cmd_t;

    function automatic logic [2:0] lane_cnt(lane_e l);
        case (l)
            LN_TWO:  return 3'd2;
            LN_FOUR: return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    function automatic logic [1:0] lane_log(lane_e l);
        case (l)
            LN_TWO:  return 2'd1;
            LN_FOUR: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/spi_mm_fifo.sv
module spi_mm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          wr_ok, rd_ok;

    assign full  = (cnt == (AW+1)'(DEPTH));
    assign empty = (cnt == '0);
    assign wr_ok = wr && !full;
    assign rd_ok = rd && !empty;
    assign rdata = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (rd_ok) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr && full && !rd) |=> $stable(cnt)) else $error("push into full queue changed occupancy"); // R11

    AST_EMPTY_POP_HARMLESS: assert property (@(posedge clk) disable iff (rst)
        (rd && empty && !wr) |=> (cnt == '0)) else $error("pop from empty queue changed occupancy"); // R12

endmodule

// File: rtl/spi_mm_engine.sv
module spi_mm_engine import spi_mm_pkg::*; #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_cpol,
    input  logic            cfg_cpha,
    input  logic [DIVW-1:0] cfg_div,
    input  logic [DIVW-1:0] cfg_lead,
    input  logic [DIVW-1:0] cfg_lag,
    input  logic            cfg_hreq_en,
    input  logic            hreq,
    input  cmd_t            cmd,
    input  logic            cmd_empty,
    output logic            cmd_pop,
    input  logic            rx_full,
    output logic            rx_push,
    output logic [DW-1:0]   rx_word,
    output logic            sck,
    output logic [NCS-1:0]  cs_n,
    output logic [NL-1:0]   sd_o,
    output logic [NL-1:0]   sd_oe,
    input  logic [NL-1:0]   sd_i
);
    state_e          st;
    logic [DIVW-1:0] cnt;
    logic [EW-1:0]   ecnt;
    logic            tog;
    logic [NCS-1:0]  csn;
    logic [DW-1:0]   sh, rsh;
    lane_e           cur_lanes;
    logic            cur_rd, cur_hold;
    logic [LW-1:0]   cur_len;

    logic [LW:0]     beats;
    logic [EW-1:0]   last_edge;
    logic            tick, do_sample, do_shift, can_go, start_ok, txmode;
    logic [NL-1:0]   in_bits, drv;

    assign beats     = ({1'b0, cur_len} + (LW+1)'(1)) >> lane_log(cur_lanes);
    assign last_edge = {beats, 1'b0} - EW'(1);
    assign tick      = (st == ST_XFER) && (cnt == cfg_div);
    assign do_sample = tick && (ecnt[0] == cfg_cpha);
    assign do_shift  = tick && (ecnt[0] != cfg_cpha) && !(cfg_cpha && ecnt == '0);
    assign can_go    = !cmd_empty && !rx_full;
    assign start_ok  = (st == ST_IDLE) && can_go && (!cfg_hreq_en || hreq);
    assign cmd_pop   = start_ok || ((st == ST_LINK) && can_go);
    assign rx_push   = (st == ST_DONE) && ((cur_lanes == LN_DUPLEX) || cur_rd);
    assign rx_word   = rsh & ({DW{1'b1}} >> (LW'(DW-1) - cur_len));
    assign txmode    = (cur_lanes == LN_DUPLEX) || !cur_rd;
    assign sck       = cfg_cpol ^ tog;
    assign cs_n      = csn;

    always_comb begin
        case (cur_lanes)
            LN_DUPLEX: in_bits = {{(NL-1){1'b0}}, sd_i[1]};
            LN_ONE:    in_bits = {{(NL-1){1'b0}}, sd_i[0]};
            LN_TWO:    in_bits = {{(NL-2){1'b0}}, sd_i[1:0]};
            default:   in_bits = sd_i;
        endcase
    end

    always_comb begin
        sd_oe = '0;
        drv   = '0;
        case (cur_lanes)
            LN_TWO:  drv = {{(NL-2){1'b0}}, sh[DW-1 -: 2]};
            LN_FOUR: drv = sh[DW-1 -: 4];
            default: drv = {{(NL-1){1'b0}}, sh[DW-1]};
        endcase
        if (st != ST_IDLE && txmode) begin
            case (cur_lanes)
                LN_TWO:  sd_oe = NL'(4'b0011);
                LN_FOUR: sd_oe = NL'(4'b1111);
                default: sd_oe = NL'(4'b0001);
            endcase
        end
        sd_o = drv & sd_oe;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            ecnt      <= '0;
            tog       <= 1'b0;
            csn       <= '1;
            sh        <= '0;
            rsh       <= '0;
            cur_lanes <= LN_DUPLEX;
            cur_rd    <= 1'b0;
            cur_hold  <= 1'b0;
            cur_len   <= '0;
        end else begin
            if (cmd_pop) begin
                sh        <= cmd.data << (LW'(DW-1) - cmd.len_m1);
                rsh       <= '0;
                cur_lanes <= cmd.lanes;
                cur_rd    <= cmd.rd;
                cur_hold  <= cmd.hold;
                cur_len   <= cmd.len_m1;
            end
            case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start_ok) begin
                        csn <= ~(NCS'(1) << cmd.cs);
                        st  <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (cnt == cfg_lead) begin
                        cnt  <= '0;
                        ecnt <= '0;
                        st   <= ST_XFER;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_XFER: begin
                    if (tick) begin
                        cnt <= '0;
                        tog <= ~tog;
                        if (do_sample) rsh <= (rsh << lane_cnt(cur_lanes)) | DW'(in_bits);
                        if (do_shift)  sh  <= sh << lane_cnt(cur_lanes);
                        if (ecnt == last_edge) st <= ST_DONE;
                        else                   ecnt <= ecnt + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DONE: begin
                    cnt <= '0;
                    st  <= cur_hold ? ST_LINK : ST_LAG;
                end
                ST_LINK: begin
                    cnt <= '0;
                    if (cmd_empty) begin
                        st <= ST_LAG;
                    end else if (!rx_full) begin
                        ecnt <= '0;
                        st   <= ST_XFER;
                    end
                end
                ST_LAG: begin
                    if (cnt == cfg_lag) begin
                        cnt <= '0;
                        csn <= '1;
                        st  <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_HREQ_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && cfg_hreq_en && !hreq) |=> (&csn)) else $error("transfer began without host request"); // R10

    AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> !rx_full) else $error("received word pushed into full queue"); // R12

    AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~csn)) else $error("more than one select line low"); // R7

    AST_SELECT_DURING_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_XFER) |-> !(&csn)) else $error("shifting with no select line low"); // R7

endmodule

// File: rtl/spi_mline_master.sv
module spi_mline_master import spi_mm_pkg::*; #(
    parameter int DEPTH = 4,
    parameter int DIVW  = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_cpol,
    input  logic            cfg_cpha,
    input  logic [DIVW-1:0] cfg_div,
    input  logic [DIVW-1:0] cfg_lead,
    input  logic [DIVW-1:0] cfg_lag,
    input  logic            cfg_hreq_en,
    input  logic            hreq,
    input  logic            cmd_we,
    input  logic [DW-1:0]   cmd_data,
    input  logic [LW-1:0]   cmd_len_m1,
    input  logic [CSW-1:0]  cmd_cs,
    input  logic [1:0]      cmd_lanes,
    input  logic            cmd_rd,
    input  logic            cmd_hold,
    output logic            cmd_full,
    input  logic            rx_re,
    output logic [DW-1:0]   rx_data,
    output logic            rx_empty,
    output logic            sck,
    output logic [NCS-1:0]  cs_n,
    output logic [NL-1:0]   sd_o,
    output logic [NL-1:0]   sd_oe,
    input  logic [NL-1:0]   sd_i
);
    cmd_t          wcmd, hcmd;
    logic          cmd_empty, cmd_pop, rx_full, rx_push;
    logic [DW-1:0] rx_word;

    always_comb begin
        wcmd.hold   = cmd_hold;
        wcmd.cs     = cmd_cs;
        wcmd.lanes  = lane_e'(cmd_lanes);
        wcmd.rd     = cmd_rd;
        wcmd.len_m1 = cmd_len_m1;
        wcmd.data   = cmd_data;
    end

    spi_mm_fifo #(.W($bits(cmd_t)), .DEPTH(DEPTH)) u_cmdq (
        .clk(clk), .rst(rst), .wr(cmd_we), .wdata(wcmd), .rd(cmd_pop),
        .rdata(hcmd), .full(cmd_full), .empty(cmd_empty)
    );

    spi_mm_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .wr(rx_push), .wdata(rx_word), .rd(rx_re),
        .rdata(rx_data), .full(rx_full), .empty(rx_empty)
    );

    spi_mm_engine #(.DIVW(DIVW)) u_engine (
        .clk(clk), .rst(rst),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_div(cfg_div),
        .cfg_lead(cfg_lead), .cfg_lag(cfg_lag),
        .cfg_hreq_en(cfg_hreq_en), .hreq(hreq),
        .cmd(hcmd), .cmd_empty(cmd_empty), .cmd_pop(cmd_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_word(rx_word),
        .sck(sck), .cs_n(cs_n), .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(sd_i)
    );

    AST_SCK_HOME: assert property (@(posedge clk) disable iff (rst)
        (&cs_n) |-> (sck == cfg_cpol)) else $error("SCK away from idle level while deselected"); // R5

    AST_LANE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        cmd_we |-> ((cmd_lanes == 2'd3) ? (cmd_len_m1[1:0] == 2'b11) :
                    (cmd_lanes == 2'd2) ? cmd_len_m1[0] : 1'b1)) else $error("frame length not a multiple of lane count"); // R3

endmodule

// File: tb/spi_mline_master_bench.sv
module spi_mline_master_bench;

    typedef struct {
        logic [31:0] tx;
        logic [31:0] rxd;
        int          len;
        int          cs;
        logic [1:0]  lanes;
        bit          rd;
        bit          hold;
    } frame_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_cpol = 0, cfg_cpha = 0, cfg_hreq_en = 0, hreq = 0;
    logic [7:0]  cfg_div = 1, cfg_lead = 2, cfg_lag = 3;
    logic        cmd_we = 0, cmd_rd = 0, cmd_hold = 0;
    logic [31:0] cmd_data = 0;
    logic [4:0]  cmd_len_m1 = 0;
    logic [1:0]  cmd_cs = 0, cmd_lanes = 0;
    logic        rx_re = 0;
    logic [3:0]  sd_i = 0;
    logic        cmd_full, rx_empty, sck;
    logic [31:0] rx_data;
    logic [3:0]  cs_n, sd_o, sd_oe;

    int checks = 0, fails = 0;
    frame_t fq[$];
    logic [31:0] rxq[$];
    bit rx_auto = 1;
    int falls = 0;

    always #2 clk = ~clk;

    spi_mline_master u_spi_mline_master (
        .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_div(cfg_div), .cfg_lead(cfg_lead), .cfg_lag(cfg_lag),
        .cfg_hreq_en(cfg_hreq_en), .hreq(hreq),
        .cmd_we(cmd_we), .cmd_data(cmd_data), .cmd_len_m1(cmd_len_m1),
        .cmd_cs(cmd_cs), .cmd_lanes(cmd_lanes), .cmd_rd(cmd_rd), .cmd_hold(cmd_hold),
        .cmd_full(cmd_full), .rx_re(rx_re), .rx_data(rx_data), .rx_empty(rx_empty),
        .sck(sck), .cs_n(cs_n), .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(sd_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int nbits(input logic [1:0] l);
        return (l == 2'd3) ? 4 : (l == 2'd2) ? 2 : 1;
    endfunction

    function automatic logic [3:0] drive(input logic [31:0] v, input logic [1:0] l);
        case (l)
            2'd0:    return {2'b00, v[31], 1'b0};
            2'd1:    return {3'b000, v[31]};
            2'd2:    return {2'b00, v[31:30]};
            default: return v[31:28];
        endcase
    endfunction

    function automatic logic [31:0] lenmask(input int len);
        return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
    endfunction

    // driver: pushes a command and records what the bus and receive queue must show
    task automatic send(input logic [31:0] tx, input logic [31:0] rxd, input int len,
                        input int cs, input logic [1:0] lanes, input bit rd, input bit hold);
        frame_t f;
        @(negedge clk);
        while (cmd_full) @(negedge clk);
        f.tx = tx & lenmask(len); f.rxd = rxd & lenmask(len); f.len = len;
        f.cs = cs; f.lanes = lanes; f.rd = rd; f.hold = hold;
        fq.push_back(f);
        if (lanes == 2'd0 || rd) rxq.push_back(f.rxd);
        cmd_we = 1; cmd_data = tx; cmd_len_m1 = 5'(len - 1); cmd_cs = 2'(cs);
        cmd_lanes = lanes; cmd_rd = rd; cmd_hold = hold;
        @(negedge clk);
        cmd_we = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (fq.size() != 0 || !(&cs_n) || (rx_auto && rxq.size() != 0)) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // monitor: slave model plus bus timing and content checks
    logic [3:0]  pcs = 4'hF;
    logic        psck = 1'b0;
    int          since_cs = 0, since_tog = 0, ecount = 0;
    bit          inf = 0, first = 0, gap = 0, last_hold = 0;
    frame_t      cf;
    logic [31:0] capt = 0, sv = 0;

    task automatic start_frame();
        ecount = 0;
        capt = 0;
        sv = cf.rxd << (32 - cf.len);
        sd_i = drive(sv, cf.lanes);
    endtask

    always @(negedge clk) begin
        if (rst) begin
            pcs = cs_n; psck = sck; inf = 0;
        end else begin
            since_cs++;
            since_tog++;
            if ((&pcs) && !(&cs_n)) begin
                falls++;
                since_cs = 0;
                if (fq.size() == 0) begin
                    chk(0, "R11", "select asserted with no expected frame", cs_n, 4'hF);
                end else begin
                    cf = fq[0];
                    chk(cs_n == ~(4'b1 << cf.cs), "R7", "select pattern", cs_n, ~(4'b1 << cf.cs));
                    start_frame();
                    first = 1; gap = 0; inf = 1;
                end
            end
            if (sck != psck && inf) begin
                if (first)
                    chk(since_cs == cfg_lead + cfg_div + 2, "R8", "select to first edge",
                        since_cs, cfg_lead + cfg_div + 2);
                else if (!gap)
                    chk(since_tog == cfg_div + 1, "R6", "SCK half period", since_tog, cfg_div + 1);
                first = 0; gap = 0; since_tog = 0;
                if ((ecount % 2) == int'(cfg_cpha)) begin
                    case (cf.lanes)
                        2'd2:    capt = (capt << 2) | 32'(sd_o[1:0]);
                        2'd3:    capt = (capt << 4) | 32'(sd_o);
                        default: capt = (capt << 1) | 32'(sd_o[0]);
                    endcase
                    if (cf.lanes != 2'd0 && cf.rd)
                        chk(sd_oe == 4'h0, "R4", "receive frame drives lines", sd_oe, 0);
                    sv = sv << nbits(cf.lanes);
                    sd_i = drive(sv, cf.lanes);
                end
                ecount++;
                if (ecount == 2 * (cf.len / nbits(cf.lanes))) begin
                    if (cf.lanes == 2'd0 || !cf.rd)
                        chk(capt == cf.tx, (cf.lanes == 2'd0) ? "R2" : "R3",
                            "transmitted word", capt, cf.tx);
                    void'(fq.pop_front());
                    last_hold = cf.hold;
                    if (cf.hold && fq.size() > 0) begin
                        cf = fq[0];
                        start_frame();
                        gap = 1;
                    end
                end
            end
            if (!(&pcs) && (&cs_n)) begin
                if (last_hold)
                    chk(since_tog == cfg_lag + 3, "R9", "underflow deselect delay", since_tog, cfg_lag + 3);
                else
                    chk(since_tog == cfg_lag + 2, "R8", "last edge to deselect", since_tog, cfg_lag + 2);
                chk(sck == cfg_cpol, "R5", "SCK idle level", sck, cfg_cpol);
                inf = 0;
            end
            pcs = cs_n;
            psck = sck;
        end
    end

    // receive side of the scoreboard
    always @(negedge clk) begin
        if (rx_re) begin
            rx_re = 0;
        end else if (!rst && rx_auto && !rx_empty) begin
            if (rxq.size() == 0)
                chk(0, "R4", "unexpected received word", rx_data, 0);
            else
                chk(rx_data == rxq[0], "R2", "received word", rx_data, rxq[0]);
            if (rxq.size() != 0) void'(rxq.pop_front());
            rx_re = 1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int f0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(cs_n == 4'hF, "R1", "selects after reset", cs_n, 4'hF);
        chk(sck == cfg_cpol, "R1", "SCK after reset", sck, cfg_cpol);
        chk(sd_oe == 4'h0, "R1", "drive enables after reset", sd_oe, 0);
        chk(rx_empty == 1'b1, "R1", "receive queue empty", rx_empty, 1);
        chk(cmd_full == 1'b0, "R1", "command queue not full", cmd_full, 0);

        // R2 full duplex, mode 0
        send(32'hA5, 32'h3C, 8, 0, 2'd0, 0, 0);
        send(32'hDEADBEEF, 32'h12345678, 32, 3, 2'd0, 0, 0);
        wait_idle();

        // R5 other polarity/phase combinations
        cfg_cpol = 1; cfg_cpha = 1; cfg_div = 0; cfg_lead = 0; cfg_lag = 0;
        send(32'hC3E1, 32'h5A0F, 16, 2, 2'd0, 0, 0);
        send(32'h1, 32'h1, 1, 1, 2'd0, 0, 0);
        wait_idle();
        cfg_cpol = 0; cfg_cpha = 1; cfg_div = 3; cfg_lead = 5; cfg_lag = 1;
        send(32'h0F0F1, 32'h7A5C3, 20, 0, 2'd0, 0, 0);
        wait_idle();
        cfg_cpol = 1; cfg_cpha = 0; cfg_div = 2; cfg_lead = 1; cfg_lag = 4;
        send(32'hBEEF, 32'h1234, 16, 3, 2'd0, 0, 0);
        wait_idle();

        // R3 R4 half-duplex lanes
        cfg_cpol = 0; cfg_cpha = 0; cfg_div = 1; cfg_lead = 2; cfg_lag = 2;
        send(32'hABC, 32'h0, 12, 1, 2'd1, 0, 0);
        send(32'h9E37, 32'h0, 16, 1, 2'd2, 0, 0);
        send(32'h13579BDF, 32'h0, 32, 2, 2'd3, 0, 0);
        send(32'h0, 32'hFEDC4321, 32, 2, 2'd3, 1, 0);
        send(32'h0, 32'hB6, 8, 0, 2'd2, 1, 0);
        send(32'h0, 32'h15, 5, 3, 2'd1, 1, 0);
        wait_idle();

        // R9 chaining and underflow
        f0 = falls;
        send(32'h11, 32'h22, 8, 1, 2'd0, 0, 1);
        send(32'h33, 32'h44, 8, 1, 2'd0, 0, 1);
        send(32'h55, 32'h66, 8, 1, 2'd0, 0, 1);
        wait_idle();
        chk(falls - f0 == 1, "R9", "one select for held chain", falls - f0, 1);
        f0 = falls;
        send(32'h7E, 32'h81, 8, 2, 2'd0, 0, 1);
        send(32'hC4, 32'h2B, 8, 2, 2'd0, 0, 0);
        wait_idle();
        chk(falls - f0 == 1, "R9", "chain closed by last word", falls - f0, 1);

        // R10 host request gate
        cfg_hreq_en = 1; hreq = 0;
        send(32'h5A, 32'hA5, 8, 0, 2'd0, 0, 0);
        repeat (40) @(negedge clk);
        chk(cs_n == 4'hF, "R10", "no start without request", cs_n, 4'hF);
        chk(fq.size() == 1, "R10", "frame still pending", fq.size(), 1);
        hreq = 1;
        wait_idle();
        chk(fq.size() == 0, "R10", "frame ran after request", fq.size(), 0);

        // R11 command queue depth and dropped push
        hreq = 0;
        f0 = falls;
        for (int i = 0; i < 4; i++) send(32'(8'h40 + i), 32'(8'h90 + i), 8, i, 2'd0, 0, 0);
        @(negedge clk);
        chk(cmd_full == 1'b1, "R11", "queue full after four pushes", cmd_full, 1);
        cmd_we = 1; cmd_data = 32'hEE; cmd_len_m1 = 5'd7; cmd_cs = 0; cmd_lanes = 0; cmd_rd = 0; cmd_hold = 0;
        @(negedge clk);
        cmd_we = 0;
        hreq = 1;
        wait_idle();
        chk(falls - f0 == 4, "R11", "fifth push dropped", falls - f0, 4);
        cfg_hreq_en = 0; hreq = 0;

        // R12 receive queue full stall
        rx_auto = 0;
        f0 = falls;
        for (int i = 0; i < 6; i++) send(32'(8'h10 + i), 32'(8'hC0 + i), 8, 1, 2'd0, 0, 0);
        repeat (200) @(negedge clk);
        chk(falls - f0 == 4, "R12", "master stalls on full receive queue", falls - f0, 4);
        chk(cs_n == 4'hF, "R12", "bus idle while stalled", cs_n, 4'hF);
        rx_auto = 1;
        wait_idle();
        chk(falls - f0 == 6, "R12", "remaining frames after drain", falls - f0, 6);
        chk(rxq.size() == 0, "R12", "no received word lost", rxq.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule